// File: doc/BRIEF.md
# Strap-addressed I2C register slave

This block lets an external two-wire bus master read and write a bank of 128 eight-bit control registers. SCL and SDA are sampled by a faster system clock. The slave answers on SDA only through an open-drain enable, and it changes SDA only while SCL is low.

The 7-bit device address is a fixed five-bit prefix, binary 00100, followed by two bits taken from strap pins. Every transfer starts with that address and a write direction bit, followed by a pointer byte. The pointer byte carries an auto-increment flag and a register index.

- In a write, data bytes follow the pointer byte directly.
- In a read, the master issues a repeated START and the address again with the read direction bit. The slave then returns register contents, starting at the index the pointer byte set.

A parallel read port gives the rest of the chip direct access to every register.

Top module: `i2c_regmap_slave`

## Requirements
- R1: The slave pulls SDA low in the ninth clock of the first byte after START only when bits 7..1 of that byte, sent MSB first, equal {5'b00100, strap_i[1], strap_i[0]}. Bit 0 of that byte is the direction: 0 means write, 1 means read.
- R2: On an address mismatch the slave never drives SDA, and it changes no register until the next START.
- R3: In a write, the slave acknowledges the pointer byte and every data byte. Each data byte is stored into the register the pointer selects.
- R4: Pointer byte bit 7 = 1 selects auto-increment. In that mode each data byte moves the pointer by one, and index 127 is followed by index 0.
- R5: Pointer byte bit 7 = 0 keeps the pointer fixed. Every data byte, written or read, uses the same register, selected by pointer bits 6..0.
- R6: After a repeated START and an address with direction 1, the slave drives register data MSB first, starting at the retained pointer. SDA changes only while SCL is low.
- R7: In a read, a master ACK (SDA low in the ninth clock) continues with the next register. A master NACK releases SDA until the next START, and the slave's SDA stays released after STOP.
- R8: START (SDA falling while SCL is high) or STOP (SDA rising while SCL is high) discards any partial byte at any time. A new address after START is decoded from its first bit.
- R9: After reset every register reads 0 and SDA is released.
- R10: rd_data_o shows, combinationally, the current content of the register selected by rd_addr_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain) |
| strap_i | input | 2 | Low two address bits, strap[1] sent first |
| rd_addr_i | input | 7 | Parallel register read index |
| rd_data_o | output | 8 | Parallel register read data |

## Verification
A bit-level bus master drives the block with several kinds of transfer:
- Single writes and bursts with the increment flag set and cleared. These separate a moving pointer from a fixed one and expose the 127-to-0 wrap.
- Addresses that differ only in a strap bit, or only in the prefix. These show whether each part of the compare is honoured, and whether the bytes that follow are ignored.
- Repeated-start reads ended by ACK or by NACK. These confirm that the pointer survives the restart and that the slave lets go of the line.
- A write aborted by STOP in mid-byte, and a START inserted after three stray bits. These confirm that the bit counter restarts on either condition.

// File: rtl/i2c_regmap_pkg.sv
package i2c_regmap_pkg;
  typedef enum logic [3:0] {
    PH_IDLE,
    PH_ADDR,
    PH_ACK_ADDR,
    PH_PTR,
    PH_ACK_PTR,
    PH_WR,
    PH_ACK_WR,
    PH_RD,
    PH_ACK_RD
  } phase_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_d, sda_d, scl_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_d  <= scl_s;
      sda_d  <= sda_o;
    end
  end

  assign scl_s      = scl_ff[STAGES-1];
  assign sda_o      = sda_ff[STAGES-1];
  assign scl_rise_o = scl_s & ~scl_d;
  assign scl_fall_o = ~scl_s & scl_d;
  assign start_o    = scl_s & scl_d & sda_d & ~sda_o;
  assign stop_o     = scl_s & scl_d & ~sda_d & sda_o;
endmodule

// File: rtl/i2c_regmap_file.sv
module i2c_regmap_file #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_a_i,
  output logic [DW-1:0] rdata_a_o,
  input  logic [AW-1:0] raddr_b_i,
  output logic [DW-1:0] rdata_b_o
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we_i) begin
      mem[waddr_i] <= wdata_i;
    end
  end

  assign rdata_a_o = mem[raddr_a_i];
  assign rdata_b_o = mem[raddr_b_i];
endmodule

// File: rtl/i2c_slave_engine.sv
module i2c_slave_engine
  import i2c_regmap_pkg::*;
#(
  parameter int             AW       = 7,
  parameter int             DW       = 8,
  parameter int             PREFIX_W = 5,
  parameter int             STRAP_W  = 2,
  parameter logic [PREFIX_W-1:0] PREFIX = 5'b00100
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sda_s_i,
  input  logic               scl_rise_i,
  input  logic               scl_fall_i,
  input  logic               start_i,
  input  logic               stop_i,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic [DW-1:0]      rdata_i,
  output logic [AW-1:0]      ptr_o,
  output logic               we_o,
  output logic [AW-1:0]      waddr_o,
  output logic [DW-1:0]      wdata_o,
  output logic               sda_oe_o
);
  localparam int BIT_W = $clog2(DW);
  localparam int DEV_W = PREFIX_W + STRAP_W;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DW - 1);

  phase_e            phase;
  logic [BIT_W-1:0]  bit_cnt;
  logic              byte_done, rw, incr, mack;
  logic [DW-1:0]     shreg, tx;
  logic [AW-1:0]     ptr;
  logic [DEV_W-1:0]  dev_addr;

  assign dev_addr = {PREFIX, strap_i};
  assign ptr_o    = ptr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase     <= PH_IDLE;
      bit_cnt   <= '0;
      byte_done <= 1'b0;
      rw        <= 1'b0;
      incr      <= 1'b0;
      mack      <= 1'b0;
      shreg     <= '0;
      tx        <= '0;
      ptr       <= '0;
      we_o      <= 1'b0;
      waddr_o   <= '0;
      wdata_o   <= '0;
      sda_oe_o  <= 1'b0;
    end else begin
      we_o <= 1'b0;
      if (start_i || stop_i) begin
        phase     <= start_i ? PH_ADDR : PH_IDLE;
        bit_cnt   <= '0;
        byte_done <= 1'b0;
        sda_oe_o  <= 1'b0;
      end else if (scl_rise_i) begin
        case (phase)
          PH_ADDR, PH_PTR, PH_WR, PH_RD: begin
            shreg     <= {shreg[DW-2:0], sda_s_i};
            bit_cnt   <= (bit_cnt == LAST_BIT) ? '0 : bit_cnt + 1'b1;
            byte_done <= (bit_cnt == LAST_BIT);
          end
          PH_ACK_RD: mack <= ~sda_s_i;
          default: ;
        endcase
      end else if (scl_fall_i) begin
        case (phase)
          PH_ADDR: if (byte_done) begin
            byte_done <= 1'b0;
            if (shreg[DW-1 -: DEV_W] == dev_addr) begin
              rw       <= shreg[0];
              sda_oe_o <= 1'b1;
              phase    <= PH_ACK_ADDR;
            end else begin
              phase <= PH_IDLE;
            end
          end
          PH_ACK_ADDR: begin
            if (rw) begin
              tx       <= rdata_i;
              sda_oe_o <= ~rdata_i[DW-1];
              phase    <= PH_RD;
            end else begin
              sda_oe_o <= 1'b0;
              phase    <= PH_PTR;
            end
          end
          PH_PTR: if (byte_done) begin
            byte_done <= 1'b0;
            incr      <= shreg[DW-1];
            ptr       <= shreg[AW-1:0];
            sda_oe_o  <= 1'b1;
            phase     <= PH_ACK_PTR;
          end
          PH_ACK_PTR: begin
            sda_oe_o <= 1'b0;
            phase    <= PH_WR;
          end
          PH_WR: if (byte_done) begin
            byte_done <= 1'b0;
            we_o      <= 1'b1;
            waddr_o   <= ptr;
            wdata_o   <= shreg;
            ptr       <= ptr + AW'(incr);
            sda_oe_o  <= 1'b1;
            phase     <= PH_ACK_WR;
          end
          PH_ACK_WR: begin
            sda_oe_o <= 1'b0;
            phase    <= PH_WR;
          end
          PH_RD: begin
            if (byte_done) begin
              byte_done <= 1'b0;
              sda_oe_o  <= 1'b0;
              ptr       <= ptr + AW'(incr);
              phase     <= PH_ACK_RD;
            end else begin
              sda_oe_o <= ~tx[DW-2];
              tx       <= {tx[DW-2:0], 1'b0};
            end
          end
          PH_ACK_RD: begin
            if (mack) begin
              tx       <= rdata_i;
              sda_oe_o <= ~rdata_i[DW-1];
              phase    <= PH_RD;
            end else begin
              sda_oe_o <= 1'b0;
              phase    <= PH_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_regmap_slave.sv
module i2c_regmap_slave #(
  parameter int SYNC_STAGES = 2,
  parameter int REG_AW      = 7,
  parameter int DATA_W      = 8,
  parameter int STRAP_W     = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe_o,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic [REG_AW-1:0]  rd_addr_i,
  output logic [DATA_W-1:0]  rd_data_o
);
  logic              sda_s, scl_rise, scl_fall, start_p, stop_p;
  logic              reg_we;
  logic [REG_AW-1:0] reg_waddr, ptr;
  logic [DATA_W-1:0] reg_wdata, ptr_data;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_p),
    .stop_o     (stop_p)
  );

  i2c_slave_engine #(
    .AW      (REG_AW),
    .DW      (DATA_W),
    .STRAP_W (STRAP_W)
  ) engine_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sda_s_i    (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_p),
    .stop_i     (stop_p),
    .strap_i    (strap_i),
    .rdata_i    (ptr_data),
    .ptr_o      (ptr),
    .we_o       (reg_we),
    .waddr_o    (reg_waddr),
    .wdata_o    (reg_wdata),
    .sda_oe_o   (sda_oe_o)
  );

  i2c_regmap_file #(.AW(REG_AW), .DW(DATA_W)) regs_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we),
    .waddr_i   (reg_waddr),
    .wdata_i   (reg_wdata),
    .raddr_a_i (ptr),
    .rdata_a_o (ptr_data),
    .raddr_b_i (rd_addr_i),
    .rdata_b_o (rd_data_o)
  );
endmodule

// File: rtl/i2c_regmap_slave_chk.sv
module i2c_regmap_slave_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_fall,
  input logic start_p,
  input logic stop_p,
  input logic reg_we,
  input logic sda_oe_o
);
  a_r6_drive_after_scl_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> $past(scl_fall));

  a_r8_start_releases_sda: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_p |=> !sda_oe_o);

  a_r7_stop_releases_sda: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_p |=> !sda_oe_o);

  a_r3_write_is_acked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we |-> sda_oe_o);

  a_r3_single_write_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we |=> !reg_we);
endmodule

bind i2c_regmap_slave i2c_regmap_slave_chk chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .scl_fall (scl_fall),
  .start_p  (start_p),
  .stop_p   (stop_p),
  .reg_we   (reg_we),
  .sda_oe_o (sda_oe_o)
);

// File: tb/i2c_regmap_slave_tb_top.sv
module i2c_regmap_slave_tb_top;
  localparam int Q = 5;
  localparam logic [4:0] PFX = 5'b00100;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_drv = 1'b1;
  logic       sda_drv = 1'b1;
  logic [1:0] strap = 2'b10;
  logic [6:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       sda_oe;
  logic       sda_line;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] mdl [128];
  logic [7:0] wq [$];

  always #10 clk = ~clk;
  assign sda_line = sda_drv & ~sda_oe;

  i2c_regmap_slave dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .scl_i     (scl_drv),
    .sda_i     (sda_line),
    .sda_oe_o  (sda_oe),
    .strap_i   (strap),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // R6: slave SDA must not move while SCL is high
  logic prev_oe = 1'b0;
  always @(negedge clk) begin
    if (rst_n && sda_oe !== prev_oe) chk("R6", "sda_oe change while scl high", scl_drv, 1'b0);
    prev_oe = sda_oe;
  end

  task automatic qwait();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_drv = 1'b1; scl_drv = 1'b1; qwait();
    sda_drv = 1'b0; qwait();
    scl_drv = 1'b0; qwait();
  endtask

  task automatic bus_restart();
    sda_drv = 1'b1; qwait();
    scl_drv = 1'b1; qwait();
    sda_drv = 1'b0; qwait();
    scl_drv = 1'b0; qwait();
  endtask

  task automatic bus_stop();
    sda_drv = 1'b0; qwait();
    scl_drv = 1'b1; qwait();
    sda_drv = 1'b1; qwait();
  endtask

  task automatic send_bit(input logic b);
    sda_drv = b; qwait();
    scl_drv = 1'b1; qwait(); qwait();
    scl_drv = 1'b0; qwait();
  endtask

  task automatic write_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_drv = 1'b1; qwait();
    scl_drv = 1'b1; qwait();
    ack = ~sda_line; qwait();
    scl_drv = 1'b0; qwait();
  endtask

  task automatic read_byte(input logic more, output logic [7:0] d);
    sda_drv = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      qwait();
      scl_drv = 1'b1; qwait();
      d[i] = sda_line; qwait();
      scl_drv = 1'b0; qwait();
    end
    send_bit(~more);
    sda_drv = 1'b1;
  endtask

  task automatic scan();
    for (int a = 0; a < 128; a++) begin
      rd_addr = 7'(a);
      @(negedge clk);
      chk("R10", "parallel read", rd_data, mdl[a]);
    end
  endtask

  task automatic check_reg(input string req, input int a, input logic [7:0] exp);
    rd_addr = 7'(a);
    @(negedge clk);
    chk(req, "register value", rd_data, exp);
  endtask

  task automatic wr_xfer(input logic [6:0] dev, input logic incr, input logic [6:0] idx);
    logic ack;
    logic hit;
    int   p;
    hit = (dev == {PFX, strap});
    bus_start();
    write_byte({dev, 1'b0}, ack);
    chk(hit ? "R1" : "R2", "address ack", ack, hit);
    write_byte({incr, idx}, ack);
    chk(hit ? "R3" : "R2", "pointer ack", ack, hit);
    p = idx;
    foreach (wq[i]) begin
      write_byte(wq[i], ack);
      chk(hit ? "R3" : "R2", "data ack", ack, hit);
      if (hit) mdl[p] = wq[i];
      if (incr) p = (p + 1) % 128;
    end
    bus_stop();
    repeat (4) @(negedge clk);
    scan();
  endtask

  task automatic rd_xfer(input logic incr, input logic [6:0] idx, input int n, input string req);
    logic       ack;
    logic [7:0] d;
    int         p;
    bus_start();
    write_byte({PFX, strap, 1'b0}, ack);
    chk("R1", "read preamble ack", ack, 1'b1);
    write_byte({incr, idx}, ack);
    chk("R3", "read pointer ack", ack, 1'b1);
    bus_restart();
    write_byte({PFX, strap, 1'b1}, ack);
    chk("R6", "read address ack", ack, 1'b1);
    p = idx;
    for (int i = 0; i < n; i++) begin
      read_byte(i != n - 1, d);
      chk(req, "read data", d, mdl[p]);
      if (incr) p = (p + 1) % 128;
    end
    repeat (4) @(negedge clk);
    chk("R7", "sda released after nack", sda_oe, 1'b0);
    bus_stop();
    repeat (4) @(negedge clk);
    chk("R7", "sda released after stop", sda_oe, 1'b0);
  endtask

  initial begin
    logic ack;
    for (int i = 0; i < 128; i++) mdl[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk("R9", "sda_oe in reset", sda_oe, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9", "sda_oe after reset", sda_oe, 1'b0);
    scan();

    // R3: single write, fixed pointer
    wq = '{8'hA5};
    wr_xfer({PFX, strap}, 1'b0, 7'd5);
    check_reg("R3", 5, 8'hA5);

    // R4: incrementing burst wraps 127 -> 0
    wq = '{8'h11, 8'h22, 8'h33};
    wr_xfer({PFX, strap}, 1'b1, 7'd126);
    check_reg("R4", 126, 8'h11);
    check_reg("R4", 127, 8'h22);
    check_reg("R4", 0, 8'h33);

    // R5: fixed-pointer burst lands on one register
    wq = '{8'h44, 8'h55, 8'h66};
    wr_xfer({PFX, strap}, 1'b0, 7'd10);
    check_reg("R5", 10, 8'h66);
    check_reg("R5", 11, 8'h00);

    // R2: strap mismatch, then prefix mismatch
    wq = '{8'hEE, 8'hEF};
    wr_xfer({PFX, 2'b01}, 1'b0, 7'd5);
    check_reg("R2", 5, 8'hA5);
    wr_xfer({5'b01000, strap}, 1'b1, 7'd5);
    check_reg("R2", 5, 8'hA5);
    check_reg("R2", 6, 8'h00);

    // R6/R7: repeated-start read across wrap, ACK then NACK
    rd_xfer(1'b1, 7'd126, 3, "R6");
    // R5: fixed-pointer read repeats one register
    rd_xfer(1'b0, 7'd10, 2, "R5");

    // R8: STOP inside a data byte discards it
    bus_start();
    write_byte({PFX, strap, 1'b0}, ack);
    write_byte({1'b1, 7'd20}, ack);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    bus_stop();
    repeat (4) @(negedge clk);
    check_reg("R8", 20, 8'h00);

    // R8: START after stray bits restarts address decode
    bus_start();
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    bus_restart();
    write_byte({PFX, strap, 1'b0}, ack);
    chk("R8", "address ack after restart", ack, 1'b1);
    write_byte({1'b0, 7'd20}, ack);
    write_byte(8'h5A, ack);
    bus_stop();
    mdl[20] = 8'h5A;
    repeat (4) @(negedge clk);
    check_reg("R8", 20, 8'h5A);

    // R1: other strap setting
    strap = 2'b01;
    repeat (4) @(negedge clk);
    wq = '{8'h77, 8'h78};
    wr_xfer({PFX, 2'b01}, 1'b1, 7'd64);
    check_reg("R1", 64, 8'h77);
    check_reg("R1", 65, 8'h78);
    rd_xfer(1'b1, 7'd64, 2, "R7");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule